// File: doc/BRIEF.md
# I2C Register-Access Slave Controller

This block is the serial front end of a small I/O-port peripheral. It oversamples the I2C clock and data lines in the system clock domain, recognises START, repeated START and STOP, answers to one 7-bit address whose low bits come from strap inputs, and turns bus traffic into simple strobes for a four-entry register bank that sits beside it.

A write transaction carries a command byte first. Its low two bits become a persistent register pointer. Every following data byte is handed to the bank with a one-cycle write strobe during the acknowledge clock. A read transaction, which may follow a repeated START or stand on its own, streams bytes from the register the pointer selects. The pointer does not advance. Before each byte is shifted out, a read strobe tells the bank to present a fresh value, so a live input register is sampled anew for every byte.

The only bus output is a pull-down enable for SDA. SCL is never held low by this block.

Top module: `i2c_regport_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 0011 followed by strap_i[2:0] (strap_i[2] most significant). Bits are received MSB first on SCL rising edges, and the acknowledge holds SDA low through the whole ninth clock.
- R2: The last bit of the address byte selects the direction: 0 means write (command byte follows) and 1 means read (the slave transmits).
- R3: In a write, the first byte after the address sets reg_sel_o to its bits [1:0], and the upper six bits are ignored. reg_sel_o keeps its value across STOP and across read transactions, and reset returns it to 0.
- R4: Each further byte in a write is committed during its acknowledge clock: wr_data_o takes the byte and wr_stb_o is high for exactly one cycle. wr_data_o changes at no other time.
- R5: No write strobe is issued while reg_sel_o selects a register marked read-only (by default register 0, the input register). wr_data_o is left unchanged.
- R6: In a read, each byte is sent MSB first. rd_stb_o pulses for one cycle at the moment the byte is captured from rd_data_i. Successive bytes come from the same register without incrementing, so register 0 returns a new sample each time.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START or STOP.
- R8: After a non-matching address, the slave drives nothing and issues no strobes until the next START or STOP.
- R9: A STOP at any point returns the slave to idle. A partly received byte is discarded without a strobe, and values from the last completed acknowledge stay in place.
- R10: A repeated START in the middle of a transaction restarts address reception, so a command write followed by a repeated START and a read address returns the newly selected register.
- R11: While rst_n is low, sda_pd_o, wr_stb_o and rd_stb_o are 0 and reg_sel_o is 0. After release the slave is idle and ignores bits until a START.
- R12: wr_stb_o and rd_stb_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| strap_i | input | 3 | Low address bits from board straps |
| sda_pd_o | output | 1 | Pull SDA low when 1 |
| reg_sel_o | output | 2 | Register pointer from the command byte |
| wr_stb_o | output | 1 | One-cycle write strobe to the register bank |
| wr_data_o | output | 8 | Byte most recently written to the bank |
| rd_stb_o | output | 1 | One-cycle strobe when a read byte is captured |
| rd_data_i | input | 8 | Register-bank value for the selected register |

## Verification
The checker watches every cycle to confirm that both strobes are single-cycle and never overlap, that a write strobe never hits a read-only register, and that the pointer and write data change only while SCL is high in an acknowledge clock. It also confirms that reset leaves the outputs quiet. Only the bench scenarios can show the serial behaviour: which address and strap combinations are acknowledged, that the pointer survives STOP, that streamed bytes from the input register are fresh while other registers repeat, and that a STOP in mid-byte, a master NACK, a foreign address or a reset in mid-transfer all leave the bus and the bank untouched.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned ADDR_W = 7;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } rp_state_e;
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic q_prev
);
   logic [STAGES:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL}};
      else        pipe_q <= {pipe_q[STAGES-1:0], d};
   end

   assign q      = pipe_q[STAGES-1];
   assign q_prev = pipe_q[STAGES];
endmodule

// File: rtl/i2c_rp_frontend.sv
module i2c_rp_frontend #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic ev_start,
   output logic ev_stop,
   output logic ev_rise,
   output logic ev_fall
);
   localparam int unsigned LINES = 2;
   localparam int unsigned L_SCL = 0;
   localparam int unsigned L_SDA = 1;

   logic [LINES-1:0] raw, cur, prv;
   assign raw = {sda_i, scl_i};

   for (genvar g = 0; g < LINES; g++) begin : g_line
      i2c_rp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .d      (raw[g]),
         .q      (cur[g]),
         .q_prev (prv[g])
      );
   end

   logic scl_hold;
   assign scl_hold = cur[L_SCL] & prv[L_SCL];
   assign sda_s    = cur[L_SDA];
   assign ev_start = scl_hold &  prv[L_SDA] & ~cur[L_SDA];
   assign ev_stop  = scl_hold & ~prv[L_SDA] &  cur[L_SDA];
   assign ev_rise  =  cur[L_SCL] & ~prv[L_SCL];
   assign ev_fall  = ~cur[L_SCL] &  prv[L_SCL];
endmodule

// File: rtl/i2c_rp_engine.sv
module i2c_rp_engine
   import i2c_rp_pkg::*;
#(
   parameter int unsigned                  STRAP_W = 3,
   parameter int unsigned                  SEL_W   = 2,
   parameter logic [ADDR_W-STRAP_W-1:0]    ADDR_HI = 4'b0011,
   parameter logic [(2**SEL_W)-1:0]        RO_MASK = 4'b0001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s,
   input  logic               ev_start,
   input  logic               ev_stop,
   input  logic               ev_rise,
   input  logic               ev_fall,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic [BYTE_W-1:0]  rd_data_i,
   output logic               sda_pd_o,
   output logic [SEL_W-1:0]   reg_sel_o,
   output logic               wr_stb_o,
   output logic [BYTE_W-1:0]  wr_data_o,
   output logic               rd_stb_o
);
   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   rp_state_e           state_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [BYTE_W-1:0]   rx_q;
   logic [BYTE_W-1:0]   tx_q;
   logic                rnw_q;
   logic                mack_q;
   logic                pd_q;
   logic [SEL_W-1:0]    ptr_q;
   logic                wstb_q;
   logic                rstb_q;
   logic [BYTE_W-1:0]   wdat_q;

   logic addr_hit;
   assign addr_hit = (rx_q[BYTE_W-1:1] == {ADDR_HI, strap_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rx_q    <= '0;
         tx_q    <= '0;
         rnw_q   <= 1'b0;
         mack_q  <= 1'b0;
         pd_q    <= 1'b0;
         ptr_q   <= '0;
         wstb_q  <= 1'b0;
         rstb_q  <= 1'b0;
         wdat_q  <= '0;
      end else begin
         wstb_q <= 1'b0;
         rstb_q <= 1'b0;
         if (ev_stop) begin
            state_q <= ST_IDLE;
            pd_q    <= 1'b0;
         end else if (ev_start) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            pd_q    <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR, ST_CMD, ST_WDATA: begin
                  if (ev_rise && cnt_q != CNT_FULL) begin
                     rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (ev_fall && cnt_q == CNT_FULL) begin
                     cnt_q <= '0;
                     if (state_q == ST_ADDR) begin
                        if (addr_hit) begin
                           state_q <= ST_ADDR_ACK;
                           rnw_q   <= rx_q[0];
                           pd_q    <= 1'b1;
                        end else begin
                           state_q <= ST_IGNORE;
                        end
                     end else if (state_q == ST_CMD) begin
                        state_q <= ST_CMD_ACK;
                        pd_q    <= 1'b1;
                     end else begin
                        state_q <= ST_WDATA_ACK;
                        pd_q    <= 1'b1;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (ev_fall) begin
                     cnt_q <= '0;
                     if (rnw_q) begin
                        state_q <= ST_RDATA;
                        tx_q    <= rd_data_i;
                        rstb_q  <= 1'b1;
                        pd_q    <= ~rd_data_i[BYTE_W-1];
                     end else begin
                        state_q <= ST_CMD;
                        pd_q    <= 1'b0;
                     end
                  end
               end
               ST_CMD_ACK: begin
                  if (ev_rise) begin
                     ptr_q <= rx_q[SEL_W-1:0];
                  end else if (ev_fall) begin
                     state_q <= ST_WDATA;
                     pd_q    <= 1'b0;
                  end
               end
               ST_WDATA_ACK: begin
                  if (ev_rise) begin
                     if (!RO_MASK[ptr_q]) begin
                        wstb_q <= 1'b1;
                        wdat_q <= rx_q;
                     end
                  end else if (ev_fall) begin
                     state_q <= ST_WDATA;
                     pd_q    <= 1'b0;
                  end
               end
               ST_RDATA: begin
                  if (ev_fall) begin
                     if (cnt_q == CNT_LAST) begin
                        state_q <= ST_RACK;
                        pd_q    <= 1'b0;
                     end else begin
                        tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                        pd_q  <= ~tx_q[BYTE_W-2];
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (ev_rise) begin
                     mack_q <= ~sda_s;
                  end else if (ev_fall) begin
                     cnt_q <= '0;
                     if (mack_q) begin
                        state_q <= ST_RDATA;
                        tx_q    <= rd_data_i;
                        rstb_q  <= 1'b1;
                        pd_q    <= ~rd_data_i[BYTE_W-1];
                     end else begin
                        state_q <= ST_IGNORE;
                     end
                  end
               end
               default: begin
                  pd_q <= 1'b0;
               end
            endcase
         end
      end
   end

   assign sda_pd_o  = pd_q;
   assign reg_sel_o = ptr_q;
   assign wr_stb_o  = wstb_q;
   assign wr_data_o = wdat_q;
   assign rd_stb_o  = rstb_q;
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
   import i2c_rp_pkg::*;
#(
   parameter int unsigned               SYNC_STAGES = 2,
   parameter int unsigned               STRAP_W     = 3,
   parameter int unsigned               SEL_W       = 2,
   parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI     = 4'b0011,
   parameter logic [(2**SEL_W)-1:0]     RO_MASK     = 4'b0001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               sda_pd_o,
   output logic [SEL_W-1:0]   reg_sel_o,
   output logic               wr_stb_o,
   output logic [BYTE_W-1:0]  wr_data_o,
   output logic               rd_stb_o,
   input  logic [BYTE_W-1:0]  rd_data_i
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STRAP_W < 1 || STRAP_W >= ADDR_W) begin : g_bad_strap
      $error("STRAP_W must leave at least one fixed address bit");
   end
   if (SEL_W < 1 || SEL_W > BYTE_W) begin : g_bad_sel
      $error("SEL_W must fit in the command byte");
   end

   logic sda_s, ev_start, ev_stop, ev_rise, ev_fall;

   i2c_rp_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .sda_s    (sda_s),
      .ev_start (ev_start),
      .ev_stop  (ev_stop),
      .ev_rise  (ev_rise),
      .ev_fall  (ev_fall)
   );

   i2c_rp_engine #(
      .STRAP_W (STRAP_W),
      .SEL_W   (SEL_W),
      .ADDR_HI (ADDR_HI),
      .RO_MASK (RO_MASK)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .ev_start  (ev_start),
      .ev_stop   (ev_stop),
      .ev_rise   (ev_rise),
      .ev_fall   (ev_fall),
      .strap_i   (strap_i),
      .rd_data_i (rd_data_i),
      .sda_pd_o  (sda_pd_o),
      .reg_sel_o (reg_sel_o),
      .wr_stb_o  (wr_stb_o),
      .wr_data_o (wr_data_o),
      .rd_stb_o  (rd_stb_o)
   );
endmodule

// File: rtl/i2c_regport_slave_chk.sv
module i2c_regport_slave_chk #(
   parameter int unsigned           SEL_W   = 2,
   parameter logic [(2**SEL_W)-1:0] RO_MASK = 4'b0001
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_i,
   input logic             sda_pd_o,
   input logic [SEL_W-1:0] reg_sel_o,
   input logic             wr_stb_o,
   input logic [7:0]       wr_data_o,
   input logic             rd_stb_o
);
   // R4: write strobe is a single-cycle pulse
   a_r4_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> !wr_stb_o);

   // R4: write data moves only together with its strobe
   a_r4_wdata_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wr_data_o) |-> wr_stb_o);

   // R4: commit happens while the acknowledge clock is high
   a_r4_commit_in_high: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |-> scl_i);

   // R3: pointer changes only during the high phase of a clock
   a_r3_sel_update_high: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_sel_o) |-> scl_i);

   // R5: read-only registers never receive a write strobe
   a_r5_ro_guard: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |-> !RO_MASK[reg_sel_o]);

   // R6: read strobe is a single-cycle pulse
   a_r6_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb_o |=> !rd_stb_o);

   // R12: strobes are mutually exclusive
   a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb_o && rd_stb_o));

   // R11: reset leaves the outputs quiet
   a_r11_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!sda_pd_o && !wr_stb_o && !rd_stb_o && reg_sel_o == '0));
endmodule

bind i2c_regport_slave i2c_regport_slave_chk #(
   .SEL_W   (SEL_W),
   .RO_MASK (RO_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_i     (scl_i),
   .sda_pd_o  (sda_pd_o),
   .reg_sel_o (reg_sel_o),
   .wr_stb_o  (wr_stb_o),
   .wr_data_o (wr_data_o),
   .rd_stb_o  (rd_stb_o)
);

// File: tb/i2c_regport_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_regport_slave_tb_top;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'd5;
   logic       sda_pd;
   logic [1:0] reg_sel;
   logic       wr_stb, rd_stb;
   logic [7:0] wr_data, rd_data;
   logic       sda_bus;

   int checks = 0, errors = 0;
   int wr_cnt = 0, rd_cnt = 0, both_cnt = 0;
   int smp_ctr = 0;
   logic [7:0] bank [1:3];
   logic [7:0] exp_bank [0:3];
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_pd;

   function automatic logic [7:0] smp(input int c);
      return 8'((c * 29) + 7);
   endfunction

   assign rd_data = (reg_sel == 2'd0) ? smp(smp_ctr) : bank[reg_sel];

   always @(posedge clk) begin
      if (wr_stb) begin
         wr_cnt <= wr_cnt + 1;
         if (reg_sel != 2'd0) bank[reg_sel] <= wr_data;
      end
      if (rd_stb) begin
         rd_cnt  <= rd_cnt + 1;
         smp_ctr <= smp_ctr + 1;
      end
      if (wr_stb && rd_stb) both_cnt <= both_cnt + 1;
   end

   i2c_regport_slave dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_bus),
      .strap_i   (strap),
      .sda_pd_o  (sda_pd),
      .reg_sel_o (reg_sel),
      .wr_stb_o  (wr_stb),
      .wr_data_o (wr_data),
      .rd_stb_o  (rd_stb),
      .rd_data_i (rd_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic do_start();
      sda_m = 1'b1; scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic do_rstart();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic do_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq();
   endtask

   task automatic put_bit(input bit b);
      sda_m = b; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic get_bit(output bit b);
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      b = sda_bus; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] v, output bit acked);
      bit r;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(r);
      acked = !r;
   endtask

   task automatic recv_byte(output logic [7:0] v, input bit give_ack);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(!give_ack);
   endtask

   function automatic logic [7:0] adr(input logic [2:0] s, input bit rd);
      return {4'b0011, s, rd};
   endfunction

   initial begin
      bit ack;
      logic [7:0] v;
      int w0, r0, c0;
      logic [7:0] wd0;
      exp_bank[0] = 8'h00;
      repeat (5) @(negedge clk);
      // R11: quiet outputs after reset
      chk(sda_pd == 1'b0 && wr_stb == 1'b0 && rd_stb == 1'b0, "R11 reset outputs", sda_pd, 0);
      chk(reg_sel == 2'd0, "R11 reset pointer", reg_sel, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 / R8: address sweep over every strap setting
      for (int s = 0; s < 8; s++) begin
         strap = 3'(s);
         for (int a = 0; a < 9; a++) begin
            logic [7:0] ab;
            ab = (a < 8) ? adr(3'(a), 1'b0) : {4'b0101, 3'(s), 1'b0};
            w0 = wr_cnt;
            do_start();
            send_byte(ab, ack);
            chk(ack == (a == s), "R1 address match", ack, (a == s));
            if (a != s) begin
               send_byte(8'h01, ack);
               chk(!ack, "R8 ignore after mismatch", ack, 0);
               send_byte(8'h00, ack);
               chk(!ack && wr_cnt == w0, "R8 no strobe after mismatch", wr_cnt - w0, 0);
            end
            do_stop();
         end
      end
      strap = 3'd5;

      // R3 / R4 / R5: single-byte write to each register
      for (int sel = 0; sel < 4; sel++) begin
         logic [7:0] d;
         d = 8'(8'hA3 + sel * 17);
         w0 = wr_cnt; wd0 = wr_data;
         do_start();
         send_byte(adr(strap, 1'b0), ack);
         send_byte({6'b000000, 2'(sel)}, ack);
         send_byte(d, ack);
         chk(ack, "R4 data acknowledged", ack, 1);
         do_stop();
         chk(reg_sel == 2'(sel), "R3 pointer from command", reg_sel, sel);
         if (sel == 0) begin
            chk(wr_cnt == w0 && wr_data == wd0, "R5 read-only write suppressed", wr_cnt - w0, 0);
         end else begin
            exp_bank[sel] = d;
            chk(wr_cnt == w0 + 1, "R4 one strobe per byte", wr_cnt - w0, 1);
            chk(wr_data == d, "R4 committed data", wr_data, d);
         end
      end

      // R3: upper command bits ignored; R4 burst of three bytes
      w0 = wr_cnt;
      do_start();
      send_byte(adr(strap, 1'b0), ack);
      send_byte(8'hFE, ack);
      send_byte(8'h11, ack);
      send_byte(8'h22, ack);
      send_byte(8'h33, ack);
      do_stop();
      exp_bank[2] = 8'h33;
      chk(reg_sel == 2'd2, "R3 upper command bits ignored", reg_sel, 2);
      chk(wr_cnt == w0 + 3, "R4 burst strobes", wr_cnt - w0, 3);
      chk(wr_data == 8'h33, "R4 burst last data", wr_data, 8'h33);

      // R10 / R6: command, repeated START, read twice from register 3
      r0 = rd_cnt;
      do_start();
      send_byte(adr(strap, 1'b0), ack);
      send_byte(8'h03, ack);
      do_rstart();
      send_byte(adr(strap, 1'b1), ack);
      chk(ack, "R2 read address acknowledged", ack, 1);
      recv_byte(v, 1'b1);
      chk(v == exp_bank[3], "R10 read after repeated START", v, exp_bank[3]);
      recv_byte(v, 1'b0);
      chk(v == exp_bank[3], "R6 repeated register, no increment", v, exp_bank[3]);
      chk(rd_cnt == r0 + 2, "R6 one read strobe per byte", rd_cnt - r0, 2);
      // R7: after NACK nothing is driven, extra clocks are ignored
      chk(sda_pd == 1'b0, "R7 released after NACK", sda_pd, 0);
      send_byte(8'h00, ack);
      chk(!ack && rd_cnt == r0 + 2, "R7 ignored until STOP", rd_cnt - r0, 2);
      do_stop();
      chk(reg_sel == 2'd3, "R3 pointer kept after STOP", reg_sel, 3);

      // R3: read-only transaction uses stored pointer
      do_start();
      send_byte(adr(strap, 1'b1), ack);
      recv_byte(v, 1'b0);
      do_stop();
      chk(v == exp_bank[3], "R3 read with stored pointer", v, exp_bank[3]);

      // R6: streaming input register gives fresh samples
      do_start();
      send_byte(adr(strap, 1'b0), ack);
      send_byte(8'h00, ack);
      do_stop();
      c0 = smp_ctr;
      do_start();
      send_byte(adr(strap, 1'b1), ack);
      for (int j = 0; j < 3; j++) begin
         recv_byte(v, j != 2);
         chk(v == smp(c0 + j), "R6 fresh sample per byte", v, smp(c0 + j));
      end
      do_stop();

      // R9: STOP in the middle of a data byte
      w0 = wr_cnt; wd0 = wr_data;
      do_start();
      send_byte(adr(strap, 1'b0), ack);
      send_byte(8'h01, ack);
      for (int i = 0; i < 4; i++) put_bit(1'b1);
      do_stop();
      chk(wr_cnt == w0 && wr_data == wd0, "R9 partial byte discarded", wr_cnt - w0, 0);
      chk(reg_sel == 2'd1, "R9 completed command kept", reg_sel, 1);
      do_start();
      send_byte(adr(strap, 1'b0), ack);
      do_stop();
      chk(ack, "R9 idle after STOP accepts new transfer", ack, 1);

      // R11: reset in the middle of a transaction
      do_start();
      send_byte(adr(strap, 1'b0), ack);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(sda_pd == 1'b0 && reg_sel == 2'd0, "R11 reset mid-transfer", reg_sel, 0);
      rst_n = 1'b1;
      w0 = wr_cnt;
      send_byte(8'h02, ack);
      chk(!ack, "R11 idle ignores bits without START", ack, 0);
      send_byte(8'h44, ack);
      chk(!ack && wr_cnt == w0 && reg_sel == 2'd0, "R11 no strobe without START", wr_cnt - w0, 0);
      do_stop();

      chk(both_cnt == 0, "R12 strobes never overlap", both_cnt, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule